// File: doc/BRIEF.md
# Duty Fade Engine

This block moves a PWM channel's duty word up or down on its own. Software loads a starting duty word, sets a step size, an interval in PWM periods, a number of steps and a direction, and then pulses a start request. From then on the engine counts period strobes from the channel. Each time the interval has elapsed it adds or subtracts the step from the whole duty word, fractional bits included. It clamps at the two ends of the word's range.

After the programmed number of steps the engine drops its busy flag and pulses a completion event for one cycle. A request with a step count of zero finishes on the next period strobe and leaves the duty unchanged. A start request while a ramp is running restarts the ramp from the present duty with the newly presented settings. The live duty word can be read at every cycle.

Top module: `duty_fade_engine`

## Requirements
- R1: After reset the duty word is 0, busy is 0 and done is 0.
- R2: A duty write while idle loads the duty word at the next clock edge. A duty write while busy has no effect on the duty word.
- R3: A start request captures step, interval, count and direction in its own cycle and sets busy at the next edge. Later changes on those inputs have no effect on the running ramp.
- R4: While busy, a step is applied on every N-th period strobe, where N is the interval value. An interval of 0 behaves as 1.
- R5: Direction input 1 adds the step to the duty word. Direction 0 subtracts it. The step is right-aligned to bit 0 of the duty word.
- R6: An addition past the all-ones value gives all ones. A subtraction below zero gives zero.
- R7: After the programmed number of steps, done is 1 for the cycle that follows the edge that applied the last step, and busy is 0 from that edge on.
- R8: With a step count of 0, the first period strobe after start raises done and clears busy, with no change to the duty word.
- R9: A start request while busy restarts the ramp from the current duty with the new settings, and its interval count begins from zero. A period strobe in the same cycle as a start request is not counted.
- R10: Period strobes while idle do not change the duty word and raise no done.
- R11: Done never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin or restart a ramp |
| step_i | input | STEP_W (10) | Amount added or removed per step |
| cycle_i | input | CYC_W (10) | Period strobes between steps (0 acts as 1) |
| count_i | input | NUM_W (10) | Total number of steps |
| up_i | input | 1 | 1 = increase duty, 0 = decrease |
| duty_wr_i | input | 1 | Load the duty word (idle only) |
| duty_wdata_i | input | DUTY_W (25) | Value loaded by a duty write |
| period_tick_i | input | 1 | One-cycle strobe at each PWM period boundary |
| duty_o | output | DUTY_W (25) | Live duty word |
| busy_o | output | 1 | A ramp is running |
| done_o | output | 1 | One-cycle ramp-completion event |

## Verification
A start request and a period strobe can arrive in the same cycle. A duty write and a running ramp can also coincide. The bench drives the start request and the strobe on the same edge partway through a ramp. It then requires that the duty word stay at its pre-restart value and that the new interval count begin from zero, which shows in when the next step lands. It also issues a duty write between strobes of an active ramp and requires the write to be dropped. An exhaustive sweep over direction, interval 0..3, count 0..3 and three step sizes compares every strobe against an arithmetic model.

// File: rtl/fade_pkg.sv
package fade_pkg;

   typedef enum logic {
      FADE_DOWN = 1'b0,
      FADE_UP   = 1'b1
   } fade_dir_e;

endpackage

// File: rtl/fade_interval_ctr.sv
// Counts accepted period strobes and fires when the programmed interval is reached.
module fade_interval_ctr #(
   parameter int CYC_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             adv_i,
   input  logic [CYC_W-1:0] limit_i,
   output logic             fire_o
);
   localparam int CW = CYC_W + 1;

   logic [CYC_W-1:0] cnt_q;
   logic [CW-1:0]    eff_lim;
   logic [CW-1:0]    cnt_nx;

   generate
      if (CYC_W < 1) begin : g_bad_width
         $error("fade_interval_ctr: CYC_W must be at least 1");
      end
   endgenerate

   always_comb begin
      eff_lim = (limit_i == '0) ? CW'(1) : {1'b0, limit_i};
      cnt_nx  = {1'b0, cnt_q} + CW'(1);
      fire_o  = adv_i && (cnt_nx >= eff_lim);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i || fire_o) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_nx[CYC_W-1:0];
      end
   end

   // R4
   cnt_below_limit_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (limit_i != '0 && adv_i && !clear_i && !fire_o) |=> (cnt_q != '0));

endmodule

// File: rtl/fade_step_unit.sv
// Combinational step: adds or subtracts the step, clamping or wrapping per SATURATE.
module fade_step_unit
   import fade_pkg::*;
#(
   parameter int DUTY_W   = 25,
   parameter int STEP_W   = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic [DUTY_W-1:0] cur_i,
   input  logic [STEP_W-1:0] step_i,
   input  fade_dir_e         dir_i,
   output logic [DUTY_W-1:0] nxt_o
);
   localparam int SW = DUTY_W + 1;

   logic [DUTY_W-1:0] step_ext;
   logic [SW-1:0]     sum;

   generate
      if (STEP_W > DUTY_W) begin : g_bad_width
         $error("fade_step_unit: STEP_W must not exceed DUTY_W");
      end
   endgenerate

   assign step_ext = DUTY_W'(step_i);
   assign sum      = {1'b0, cur_i} + {1'b0, step_ext};

   generate
      if (SATURATE) begin : g_clamp
         always_comb begin
            if (dir_i == FADE_UP) begin
               nxt_o = sum[DUTY_W] ? {DUTY_W{1'b1}} : sum[DUTY_W-1:0];
            end else begin
               nxt_o = (cur_i < step_ext) ? '0 : (cur_i - step_ext);
            end
         end
         // R6
         always_comb begin
            clamp_dir_chk : assert ((dir_i == FADE_UP) ? (nxt_o >= cur_i) : (nxt_o <= cur_i));
         end
      end else begin : g_wrap
         always_comb begin
            if (dir_i == FADE_UP) nxt_o = sum[DUTY_W-1:0];
            else                  nxt_o = cur_i - step_ext;
         end
      end
   endgenerate

endmodule

// File: rtl/fade_seq.sv
// Tracks busy state and remaining steps; produces the done event.
module fade_seq #(
   parameter int NUM_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [NUM_W-1:0] count_i,
   input  logic             period_tick_i,
   input  logic             fire_i,
   output logic             adv_o,
   output logic             busy_o,
   output logic             done_o
);
   logic [NUM_W-1:0] rem_q;
   logic             tick_ok;
   logic             zero_end;

   generate
      if (NUM_W < 1) begin : g_bad_width
         $error("fade_seq: NUM_W must be at least 1");
      end
   endgenerate

   assign tick_ok  = period_tick_i && busy_o && !start_i;
   assign zero_end = tick_ok && (rem_q == '0);
   assign adv_o    = tick_ok && (rem_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         rem_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            busy_o <= 1'b1;
            rem_q  <= count_i;
         end else if (zero_end) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end else if (fire_i) begin
            rem_q <= rem_q - NUM_W'(1);
            if (rem_q == NUM_W'(1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   // R11
   done_single_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R7
   done_idle_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R3
   rem_no_rise_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (rem_q <= $past(rem_q)));

   // R3
   start_busy_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o);

endmodule

// File: rtl/duty_fade_engine.sv
module duty_fade_engine
   import fade_pkg::*;
#(
   parameter int DUTY_W   = 25,
   parameter int STEP_W   = 10,
   parameter int CYC_W    = 10,
   parameter int NUM_W    = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic [CYC_W-1:0]  cycle_i,
   input  logic [NUM_W-1:0]  count_i,
   input  logic              up_i,
   input  logic              duty_wr_i,
   input  logic [DUTY_W-1:0] duty_wdata_i,
   input  logic              period_tick_i,
   output logic [DUTY_W-1:0] duty_o,
   output logic              busy_o,
   output logic              done_o
);
   logic [STEP_W-1:0] step_q;
   logic [CYC_W-1:0]  cyc_q;
   fade_dir_e         dir_q;
   logic [DUTY_W-1:0] duty_q;
   logic [DUTY_W-1:0] duty_nx;
   logic              adv;
   logic              fire;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_q <= '0;
         cyc_q  <= '0;
         dir_q  <= FADE_DOWN;
      end else if (start_i) begin
         step_q <= step_i;
         cyc_q  <= cycle_i;
         dir_q  <= fade_dir_e'(up_i);
      end
   end

   fade_seq #(.NUM_W(NUM_W)) u_seq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .start_i       (start_i),
      .count_i       (count_i),
      .period_tick_i (period_tick_i),
      .fire_i        (fire),
      .adv_o         (adv),
      .busy_o        (busy_o),
      .done_o        (done_o)
   );

   fade_interval_ctr #(.CYC_W(CYC_W)) u_ivl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (start_i),
      .adv_i   (adv),
      .limit_i (cyc_q),
      .fire_o  (fire)
   );

   fade_step_unit #(
      .DUTY_W   (DUTY_W),
      .STEP_W   (STEP_W),
      .SATURATE (SATURATE)
   ) u_step (
      .cur_i  (duty_q),
      .step_i (step_q),
      .dir_i  (dir_q),
      .nxt_o  (duty_nx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         duty_q <= '0;
      end else if (duty_wr_i && !busy_o) begin
         duty_q <= duty_wdata_i;
      end else if (fire) begin
         duty_q <= duty_nx;
      end
   end

   assign duty_o = duty_q;

   // R10
   idle_hold_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !duty_wr_i) |=> $stable(duty_o));

   // R2
   busy_wr_drop_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !period_tick_i) |=> $stable(duty_o));

   // R9
   start_tick_drop_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_o) |=> $stable(duty_o));

   // R10
   idle_no_done_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> !done_o);

endmodule

// File: tb/tb_duty_fade_engine.sv
`timescale 1ns/1ps
module tb_duty_fade_engine;
   localparam int DW = 25;
   localparam logic [DW-1:0] MAXV = {DW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [9:0]    step = '0;
   logic [9:0]    cyc = '0;
   logic [9:0]    num = '0;
   logic          up = 1'b0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          tick = 1'b0;
   logic [DW-1:0] duty;
   logic          busy;
   logic          done;

   int checks = 0;
   int errors = 0;

   // model state
   logic [DW-1:0] m_duty;
   int            m_rem, m_cnt, m_eff, m_step;
   bit            m_busy, m_done, m_up;

   always #5 clk = ~clk;

   duty_fade_engine dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
      .cycle_i(cyc), .count_i(num), .up_i(up), .duty_wr_i(wr),
      .duty_wdata_i(wdata), .period_tick_i(tick), .duty_o(duty),
      .busy_o(busy), .done_o(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] apply(input logic [DW-1:0] d, input int s, input bit u);
      longint v;
      v = u ? longint'(d) + s : longint'(d) - s;
      if (v < 0) v = 0;
      if (v > longint'(MAXV)) v = longint'(MAXV);
      return DW'(v);
   endfunction

   task automatic model_tick();
      m_done = 0;
      if (!m_busy) return;
      if (m_rem == 0) begin
         m_done = 1; m_busy = 0;
      end else begin
         m_cnt++;
         if (m_cnt >= m_eff) begin
            m_cnt = 0;
            m_duty = apply(m_duty, m_step, m_up);
            m_rem--;
            if (m_rem == 0) begin m_done = 1; m_busy = 0; end
         end
      end
   endtask

   task automatic do_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic load_duty(input logic [DW-1:0] v);
      @(negedge clk) begin wr = 1'b1; wdata = v; end
      @(negedge clk) wr = 1'b0;
      m_duty = v;
   endtask

   task automatic go(input bit u, input int c, input int n, input int s, input bit with_tick);
      @(negedge clk) begin
         start = 1'b1; up = u; cyc = 10'(c); num = 10'(n); step = 10'(s);
         tick = with_tick;
      end
      @(negedge clk) begin
         start = 1'b0; tick = 1'b0;
         up = ~u; cyc = 10'd7; num = 10'd9; step = 10'd333; // R3 scramble
      end
      m_busy = 1; m_rem = n; m_cnt = 0; m_step = s; m_up = u;
      m_eff = (c == 0) ? 1 : c;
      m_done = 0;
   endtask

   task automatic run_ticks(input int k, input string tag);
      for (int t = 0; t < k; t++) begin
         do_tick();
         model_tick();
         chk(tag, 32'(duty), 32'(m_duty));
         chk("R7", 32'(done), 32'(m_done));
         chk("R7", 32'(busy), 32'(m_busy));
         @(negedge clk);
         chk("R11", 32'(done), 32'd0);
      end
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int steps[3] = '{1, 5, 1023};
      repeat (3) @(negedge clk);
      // R1
      chk("R1", 32'(duty), 32'd0);
      chk("R1", 32'(busy), 32'd0);
      chk("R1", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: idle strobes
      load_duty(25'd77);
      chk("R2", 32'(duty), 32'd77);
      do_tick();
      chk("R10", 32'(duty), 32'd77);
      chk("R10", 32'(done), 32'd0);

      // exhaustive sweep
      for (int u = 0; u < 2; u++)
         for (int c = 0; c < 4; c++)
            for (int n = 0; n < 4; n++)
               for (int si = 0; si < 3; si++) begin
                  load_duty(25'd2000);
                  chk("R2", 32'(duty), 32'd2000);
                  go(u[0], c, n, steps[si], 1'b0);
                  chk("R3", 32'(busy), 32'd1);
                  if (n == 0) begin
                     do_tick(); model_tick();
                     chk("R8", 32'(duty), 32'd2000);
                     chk("R8", 32'(done), 32'd1);
                     chk("R8", 32'(busy), 32'd0);
                     run_ticks(1, "R10");
                  end else begin
                     run_ticks(n * ((c == 0) ? 1 : c) + 1, (u == 1) ? "R5" : "R4");
                  end
               end

      // R6 saturation up
      load_duty(MAXV - 25'd16);
      go(1'b1, 1, 2, 1023, 1'b0);
      run_ticks(3, "R6");
      chk("R6", 32'(duty), 32'(MAXV));
      // R6 saturation down
      load_duty(25'd10);
      go(1'b0, 1, 1, 1023, 1'b0);
      run_ticks(2, "R6");
      chk("R6", 32'(duty), 32'd0);

      // R2 write while busy dropped; R9 restart with same-cycle strobe
      load_duty(25'd100);
      go(1'b1, 2, 5, 5, 1'b0);
      run_ticks(2, "R4");
      chk("R4", 32'(duty), 32'd105);
      @(negedge clk) begin wr = 1'b1; wdata = 25'd999; end
      @(negedge clk) wr = 1'b0;
      chk("R2", 32'(duty), 32'd105);
      go(1'b0, 2, 2, 3, 1'b1);
      chk("R9", 32'(duty), 32'd105);
      chk("R9", 32'(busy), 32'd1);
      run_ticks(1, "R9");
      chk("R9", 32'(duty), 32'd105);
      run_ticks(4, "R9");
      chk("R9", 32'(duty), 32'd99);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule